// File: doc/BRIEF.md
# DMA Channel Cycle-Type Sequencer

This block sequences the DMA cycle of a single channel. It holds two control structures, a primary and an alternate. Each one carries a cycle kind, a transfer count and a chunk exponent. When a request arrives, the block reads the active structure. It asks the system arbiter for the bus and then enables transfers one by one. It counts the transfers in chunks of 2^R, and at each chunk boundary it decides whether to re-arbitrate, wait for a fresh request, or carry on. Data movement is outside the block: a transfer engine watches `xfer_en` and strobes `xfer_done` once for each finished transfer.

When a cycle ends, the block writes the finished structure's kind back to invalid, so the same cycle cannot run again, and raises `dma_done` for one clock. In ping-pong operation it then swaps to the other structure. Software can refill the structure that is not in use while the other one is running. There is no data stream at the block's edge. The `xfer_en`/`xfer_done` pair works as a plain enable and completion strobe: while `xfer_en` stays high and `xfer_done` is low, the block waits, and that is the only form of back-pressure. All other pins are plain control levels.

Top module: `dma_cycle_seq`

## Requirements
- R1: After reset, `xfer_en`, `dma_done` and `use_alt` are low and both structures hold the invalid kind.
- R2: A write on the configuration port stores a structure. Kind codes are 0 invalid, 1 basic, 2 auto-request and 3 ping-pong. The count field (10 bits) holds N-1, so one cycle covers 1 to 1024 transfers. The exponent field (4 bits) sets the chunk size to 2^R, and any R of 10 or more covers the whole cycle in one chunk.
- R3: A request is ignored, with no transfer and no `dma_done`, when the active structure is invalid or `chan_en` is low.
- R4: After a request is accepted, `xfer_en` stays low until `gnt` is sampled high with the channel enabled.
- R5: Basic kind: each accepted request yields at most 2^R transfers. If transfers remain after a chunk, the block waits for a new request.
- R6: Auto-request kind: a single request runs all N transfers. Between chunks, `xfer_en` drops for at least one clock while the block re-arbitrates.
- R7: A cycle performs exactly N transfers, in ceil(N / 2^R) chunks. Every chunk except the last holds 2^R transfers.
- R8: `dma_done` is high for exactly one clock, in the cycle after the edge that accepts the cycle's last `xfer_done`.
- R9: Completion sets the finished structure's kind to invalid, so a later request on it is ignored.
- R10: Ping-pong kind: on completion `use_alt` toggles. If the channel is still enabled and the other structure is auto-request or ping-pong, the next cycle starts without a request. If the other structure is basic, the block waits for a request. If it is invalid, or the channel is disabled, the sequence stops.
- R11: A write to the inactive structure during an active ping-pong cycle takes effect when that cycle completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enable |
| req | input | 1 | Hardware or software request |
| gnt | input | 1 | Arbitration grant for this channel |
| xfer_done | input | 1 | One transfer finished (valid while `xfer_en` is high) |
| cfg_we | input | 1 | Structure write strobe |
| cfg_alt | input | 1 | Structure written: 0 primary, 1 alternate |
| cfg_kind | input | 2 | Cycle kind code |
| cfg_cnt | input | 10 | Transfer count minus one |
| cfg_rpow | input | 4 | Chunk exponent R |
| use_alt | output | 1 | Active structure: 0 primary, 1 alternate |
| xfer_en | output | 1 | Transfer enable toward the data engine |
| dma_done | output | 1 | Cycle-complete pulse |

## Verification
Assertions check the following on every clock:
- `dma_done` never lasts two cycles.
- No transfer is enabled while the grant is withheld.
- A request against an invalid structure never leaves idle.
- A waiting basic cycle stays quiet until a request arrives.
- The remaining count falls by one per accepted transfer.
- A finished structure reads invalid on the next edge.
- A finished ping-pong cycle flips the select.

Other properties need multi-cycle scenarios and only the bench's sweeps can show them. These are the total transfer count and the number of chunks across many N and R pairs, the different responses of basic and auto-request to a single request, and the ping-pong hand-over that continues, pauses or stops depending on the other structure and on the channel enable.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    CK_INVALID  = 2'd0,
    CK_BASIC    = 2'd1,
    CK_AUTO     = 2'd2,
    CK_PINGPONG = 2'd3
  } cyc_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARB,
    ST_RUN,
    ST_WAIT
  } seq_state_e;

endpackage

// File: rtl/dma_desc_store.sv
module dma_desc_store
  import dma_seq_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int RPW_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_alt,
  input  cyc_kind_e        wr_kind,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic [RPW_W-1:0] wr_rpow,
  input  logic             inv_en,
  input  logic             inv_alt,
  input  logic             rd_alt,
  output cyc_kind_e        cur_kind,
  output logic [CNT_W-1:0] cur_cnt,
  output logic [RPW_W-1:0] cur_rpow,
  output cyc_kind_e        oth_kind,
  output logic [CNT_W-1:0] oth_cnt,
  output logic [RPW_W-1:0] oth_rpow
);

  localparam int NUM_ENT = 2;

  cyc_kind_e        kind_q [NUM_ENT];
  logic [CNT_W-1:0] cnt_q  [NUM_ENT];
  logic [RPW_W-1:0] rpow_q [NUM_ENT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ENT; i++) begin
        kind_q[i] <= CK_INVALID;
        cnt_q[i]  <= '0;
        rpow_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_ENT; i++) begin
        if (wr_en && (wr_alt == 1'(i))) begin
          kind_q[i] <= wr_kind;
          cnt_q[i]  <= wr_cnt;
          rpow_q[i] <= wr_rpow;
        end else if (inv_en && (inv_alt == 1'(i))) begin
          kind_q[i] <= CK_INVALID;
        end
      end
    end
  end

  always_comb begin
    cur_kind = kind_q[rd_alt];
    cur_cnt  = cnt_q[rd_alt];
    cur_rpow = rpow_q[rd_alt];
    oth_kind = kind_q[!rd_alt];
    oth_cnt  = cnt_q[!rd_alt];
    oth_rpow = rpow_q[!rd_alt];
  end

  AST_CLEAR_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && !(wr_en && (wr_alt == inv_alt))) |=> (kind_q[$past(inv_alt)] == CK_INVALID)); // R9

endmodule

// File: rtl/dma_xfer_counter.sv
module dma_xfer_counter
  import dma_seq_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int RPW_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_cyc,
  input  logic [CNT_W-1:0] cnt_in,
  input  logic [RPW_W-1:0] rpow_in,
  input  logic             load_chunk,
  input  logic             step,
  output logic             last_xfer,
  output logic             chunk_end
);

  logic [CNT_W-1:0] rem_q;
  logic [CNT_W-1:0] chk_q;
  logic [RPW_W-1:0] rpow_q;
  logic [CNT_W-1:0] chunk_init;
  logic [CNT_W:0]   pow_v;

  // chunk length minus one; exponents at or above the count width saturate
  always_comb begin
    pow_v = {{CNT_W{1'b0}}, 1'b1} << rpow_q;
    if (32'(rpow_q) >= CNT_W) chunk_init = '1;
    else                      chunk_init = pow_v[CNT_W-1:0] - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      rpow_q <= '0;
    end else if (load_cyc) begin
      rem_q  <= cnt_in;
      rpow_q <= rpow_in;
    end else if (step && (rem_q != '0)) begin
      rem_q <= rem_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      chk_q <= '0;
    else if (load_chunk)             chk_q <= chunk_init;
    else if (step && (chk_q != '0))  chk_q <= chk_q - CNT_W'(1);
  end

  assign last_xfer = (rem_q == '0);
  assign chunk_end = (chk_q == '0);

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_cyc && (rem_q != '0)) |=> (rem_q == $past(rem_q) - CNT_W'(1))); // R7

endmodule

// File: rtl/dma_cycle_fsm.sv
module dma_cycle_fsm
  import dma_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      chan_en,
  input  logic      req,
  input  logic      gnt,
  input  logic      xfer_done,
  input  cyc_kind_e cur_kind,
  input  cyc_kind_e oth_kind,
  input  logic      last_xfer,
  input  logic      chunk_end,
  output logic      use_alt,
  output logic      xfer_en,
  output logic      dma_done,
  output logic      load_cyc,
  output logic      load_other,
  output logic      load_chunk,
  output logic      step,
  output logic      inv_en,
  output logic      inv_alt
);

  seq_state_e st_q, st_d;
  cyc_kind_e  mode_q;
  logic       alt_q;
  logic       done_q;
  logic       start, finish, pp_go, oth_runs;

  assign oth_runs   = (oth_kind == CK_AUTO) || (oth_kind == CK_PINGPONG);
  assign start      = (st_q == ST_IDLE) && chan_en && req && (cur_kind != CK_INVALID);
  assign step       = (st_q == ST_RUN) && xfer_done;
  assign finish     = step && last_xfer;
  assign pp_go      = finish && (mode_q == CK_PINGPONG) && chan_en && oth_runs;
  assign load_cyc   = start || pp_go;
  assign load_other = pp_go;
  assign load_chunk = (st_q == ST_ARB) && chan_en && gnt;
  assign inv_en     = finish;
  assign inv_alt    = alt_q;
  assign xfer_en    = (st_q == ST_RUN);
  assign use_alt    = alt_q;
  assign dma_done   = done_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (start) st_d = ST_ARB;
      ST_ARB: begin
        if (!chan_en) st_d = ST_IDLE;
        else if (gnt) st_d = ST_RUN;
      end
      ST_RUN: begin
        if (step) begin
          if (last_xfer)                st_d = pp_go ? ST_ARB : ST_IDLE;
          else if (chunk_end)           st_d = (mode_q == CK_BASIC) ? ST_WAIT : ST_ARB;
        end
      end
      ST_WAIT: begin
        if (!chan_en) st_d = ST_IDLE;
        else if (req) st_d = ST_ARB;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      mode_q <= CK_INVALID;
      alt_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= finish;
      if (start)      mode_q <= cur_kind;
      else if (pp_go) mode_q <= oth_kind;
      if (finish && (mode_q == CK_PINGPONG)) alt_q <= !alt_q;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done |=> !dma_done); // R8

  AST_NO_XFER_WITHOUT_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_ARB) && !gnt) |=> !xfer_en); // R4

  AST_INVALID_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_IDLE) && (cur_kind == CK_INVALID)) |=> ((st_q == ST_IDLE) && !xfer_en)); // R3

  AST_BASIC_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_WAIT) && !req) |=> !xfer_en); // R5

  AST_PP_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && (mode_q == CK_PINGPONG)) |=> (use_alt != $past(use_alt))); // R10

endmodule

// File: rtl/dma_cycle_seq.sv
module dma_cycle_seq
  import dma_seq_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int RPW_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_en,
  input  logic             req,
  input  logic             gnt,
  input  logic             xfer_done,
  input  logic             cfg_we,
  input  logic             cfg_alt,
  input  logic [1:0]       cfg_kind,
  input  logic [CNT_W-1:0] cfg_cnt,
  input  logic [RPW_W-1:0] cfg_rpow,
  output logic             use_alt,
  output logic             xfer_en,
  output logic             dma_done
);

  cyc_kind_e        cur_kind, oth_kind;
  logic [CNT_W-1:0] cur_cnt, oth_cnt, ld_cnt;
  logic [RPW_W-1:0] cur_rpow, oth_rpow, ld_rpow;
  logic             load_cyc, load_other, load_chunk, step;
  logic             inv_en, inv_alt, last_xfer, chunk_end;

  dma_desc_store #(.CNT_W(CNT_W), .RPW_W(RPW_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_alt   (cfg_alt),
    .wr_kind  (cyc_kind_e'(cfg_kind)),
    .wr_cnt   (cfg_cnt),
    .wr_rpow  (cfg_rpow),
    .inv_en   (inv_en),
    .inv_alt  (inv_alt),
    .rd_alt   (use_alt),
    .cur_kind (cur_kind),
    .cur_cnt  (cur_cnt),
    .cur_rpow (cur_rpow),
    .oth_kind (oth_kind),
    .oth_cnt  (oth_cnt),
    .oth_rpow (oth_rpow)
  );

  // a ping-pong hand-over loads the structure that is about to become active
  assign ld_cnt  = load_other ? oth_cnt  : cur_cnt;
  assign ld_rpow = load_other ? oth_rpow : cur_rpow;

  dma_xfer_counter #(.CNT_W(CNT_W), .RPW_W(RPW_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_cyc   (load_cyc),
    .cnt_in     (ld_cnt),
    .rpow_in    (ld_rpow),
    .load_chunk (load_chunk),
    .step       (step),
    .last_xfer  (last_xfer),
    .chunk_end  (chunk_end)
  );

  dma_cycle_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .chan_en    (chan_en),
    .req        (req),
    .gnt        (gnt),
    .xfer_done  (xfer_done),
    .cur_kind   (cur_kind),
    .oth_kind   (oth_kind),
    .last_xfer  (last_xfer),
    .chunk_end  (chunk_end),
    .use_alt    (use_alt),
    .xfer_en    (xfer_en),
    .dma_done   (dma_done),
    .load_cyc   (load_cyc),
    .load_other (load_other),
    .load_chunk (load_chunk),
    .step       (step),
    .inv_en     (inv_en),
    .inv_alt    (inv_alt)
  );

endmodule

// File: tb/dma_cycle_seq_bench.sv
`timescale 1ns/1ps
module dma_cycle_seq_bench;

  localparam int CW = 10;
  localparam int RW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          chan_en = 1'b1;
  logic          req = 1'b0;
  logic          gnt = 1'b1;
  logic          xfer_done;
  logic          cfg_we = 1'b0;
  logic          cfg_alt = 1'b0;
  logic [1:0]    cfg_kind = 2'd0;
  logic [CW-1:0] cfg_cnt = '0;
  logic [RW-1:0] cfg_rpow = '0;
  logic          use_alt, xfer_en, dma_done;

  int errors = 0;
  int checks = 0;
  int n_xfer, n_rise, n_done;

  always #5 clk = ~clk;

  // the engine finishes each enabled transfer in one clock
  assign xfer_done = xfer_en;

  dma_cycle_seq #(.CNT_W(CW), .RPW_W(RW)) u_dma_cycle_seq (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .req(req), .gnt(gnt),
    .xfer_done(xfer_done), .cfg_we(cfg_we), .cfg_alt(cfg_alt),
    .cfg_kind(cfg_kind), .cfg_cnt(cfg_cnt), .cfg_rpow(cfg_rpow),
    .use_alt(use_alt), .xfer_en(xfer_en), .dma_done(dma_done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req = 1'b0; cfg_we = 1'b0; chan_en = 1'b1; gnt = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic set_cfg(input int alt, input int kind, input int n, input int r);
    cfg_alt  = 1'(alt);
    cfg_kind = 2'(kind);
    cfg_cnt  = CW'(n - 1);
    cfg_rpow = RW'(r);
  endtask

  task automatic wr_desc(input int alt, input int kind, input int n, input int r);
    @(negedge clk);
    set_cfg(alt, kind, n, r);
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // req_mode: 0 one-cycle pulse at start, 1 held high, 2 none
  task automatic observe(input int cycles, input int req_mode, input int en_off_at, input int wr_at);
    logic prev_x;
    prev_x = 1'b0;
    n_xfer = 0; n_rise = 0; n_done = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (xfer_en) n_xfer++;
      if (xfer_en && !prev_x) n_rise++;
      prev_x = xfer_en;
      if (dma_done) n_done++;
      req = (req_mode == 1) || (req_mode == 0 && i == 0);
      if (i == en_off_at) chan_en = 1'b0;
      cfg_we = (i == wr_at);
    end
    req = 1'b0;
    cfg_we = 1'b0;
  endtask

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  initial begin
    #1_500_000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk("R1 xfer_en after reset", int'(xfer_en), 0);
    chk("R1 dma_done after reset", int'(dma_done), 0);
    chk("R1 use_alt after reset", int'(use_alt), 0);

    // both structures invalid after reset: a held request does nothing
    observe(10, 1, -1, -1);
    chk("R1 R3 invalid start xfers", n_xfer, 0);
    chk("R3 invalid start done", n_done, 0);

    // sweep basic and auto-request over count and exponent
    for (int kind = 1; kind <= 2; kind++) begin
      for (int r = 0; r <= 3; r++) begin
        for (int n = 1; n <= 9; n++) begin
          int c;
          c = 1 << r;
          wr_desc(0, kind, n, r);
          if (kind == 1) begin
            observe(40, 0, -1, -1);
            chk("R5 basic first chunk xfers", n_xfer, (n < c) ? n : c);
            chk("R5 basic first chunk done", n_done, (n <= c) ? 1 : 0);
            if (n > c) begin
              observe(60, 1, -1, -1);
              chk("R7 basic rest xfers", n_xfer, n - c);
              chk("R7 basic rest chunks", n_rise, ceil_div(n - c, c));
              chk("R8 basic done pulse", n_done, 1);
            end
          end else begin
            observe(40, 0, -1, -1);
            chk("R6 auto xfers", n_xfer, n);
            chk("R6 R7 auto chunks", n_rise, ceil_div(n, c));
            chk("R8 auto done pulse", n_done, 1);
          end
          observe(8, 1, -1, -1);
          chk("R9 reissued request xfers", n_xfer, 0);
          chk("R9 reissued request done", n_done, 0);
        end
      end
    end

    // largest count with a saturating exponent: one chunk
    wr_desc(0, 2, 1024, 15);
    observe(1040, 0, -1, -1);
    chk("R2 max count xfers", n_xfer, 1024);
    chk("R2 saturated exponent chunks", n_rise, 1);
    chk("R8 max count done", n_done, 1);

    // disabled channel ignores a request
    chan_en = 1'b0;
    wr_desc(0, 2, 4, 3);
    observe(10, 0, -1, -1);
    chk("R3 disabled xfers", n_xfer, 0);
    chk("R3 disabled done", n_done, 0);
    chan_en = 1'b1;
    observe(20, 0, -1, -1);
    chk("R3 enabled xfers", n_xfer, 4);

    // grant withheld
    gnt = 1'b0;
    wr_desc(0, 2, 3, 3);
    observe(10, 0, -1, -1);
    chk("R4 no grant xfers", n_xfer, 0);
    gnt = 1'b1;
    observe(20, 2, -1, -1);
    chk("R4 granted xfers", n_xfer, 3);
    chk("R4 granted done", n_done, 1);

    // ping-pong through both structures, then stop on invalid
    do_reset();
    wr_desc(0, 3, 3, 3);
    wr_desc(1, 3, 2, 3);
    observe(30, 0, -1, -1);
    chk("R10 pp chain xfers", n_xfer, 5);
    chk("R10 pp chain dones", n_done, 2);
    chk("R10 pp chain select", int'(use_alt), 0);

    // ping-pong handing over to basic
    do_reset();
    wr_desc(0, 3, 2, 3);
    wr_desc(1, 1, 3, 3);
    observe(20, 0, -1, -1);
    chk("R10 pp to basic xfers", n_xfer, 2);
    chk("R10 pp to basic select", int'(use_alt), 1);
    observe(20, 0, -1, -1);
    chk("R10 basic on alternate xfers", n_xfer, 3);
    chk("R10 basic on alternate done", n_done, 1);
    chk("R10 basic keeps select", int'(use_alt), 1);
    observe(10, 1, -1, -1);
    chk("R9 alternate invalidated", n_xfer, 0);

    // channel disabled during ping-pong stops the hand-over
    do_reset();
    wr_desc(0, 3, 2, 3);
    wr_desc(1, 3, 2, 3);
    observe(20, 0, 2, -1);
    chk("R10 disabled pp xfers", n_xfer, 2);
    chk("R10 disabled pp done", n_done, 1);
    chk("R10 disabled pp select", int'(use_alt), 1);
    chan_en = 1'b1;
    observe(10, 2, -1, -1);
    chk("R10 no restart without request", n_xfer, 0);
    observe(20, 0, -1, -1);
    chk("R10 resumed alternate xfers", n_xfer, 2);
    chk("R10 resumed select", int'(use_alt), 0);

    // refill the inactive structure while the active one runs
    do_reset();
    wr_desc(0, 3, 4, 3);
    @(negedge clk);
    set_cfg(1, 3, 2, 3);
    observe(30, 0, -1, 2);
    chk("R11 refill xfers", n_xfer, 6);
    chk("R11 refill dones", n_done, 2);
    chk("R11 refill select", int'(use_alt), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule